// File: doc/BRIEF.md
# Branch Resolution Unit

This block executes one branch operation per cycle in a 64-bit processor. Each operation arrives already decoded into fields, together with the address of the branch, the condition register and the count, link and target-address registers. One cycle later the unit returns three results. The first is the next fetch address with a flag that says whether the branch redirects the flow. The second is a link-register write. The third is an optional count-register write.

Three branch forms are supported. The immediate form always branches by a signed 24-bit word displacement. The conditional form branches by a signed 14-bit word displacement when its tests pass. The register form branches to an address held in the link, count or target-address register when its tests pass. The tests are a condition-register bit test and a count test. The count test is applied to the count value after it has been decremented, so a count of one reaches zero in the same branch. The unit has no stall path: every valid input produces a valid result on the next cycle.

Top module: `branch_resolve`

## Requirements
- R1: `res_vld` equals the value `op_vld` had one cycle earlier. While `res_vld` is 0, `nia_taken`, `lr_we` and `ctr_we` are 0. All outputs are 0 during reset.
- R2: Immediate form (`op_form`=0) is always taken. `nia` = base + sign-extended `disp[23:0]`×4, where base is 0 if `op_abs`=1 and is otherwise `cia`.
- R3: Conditional form (`op_form`=1) computes its target the same way from the sign-extended `disp[13:0]`×4. The branch is taken only when both the condition test and the count test pass.
- R4: Condition test. If `bo[4]`=1 the test passes. Otherwise it passes when `cr[31-bi]` equals `bo[3]`, so `bi`=0 selects the most significant bit.
- R5: If `bo[2]`=0 in form 1 or form 2, the count is decremented: `ctr_we`=1 and `ctr_wdata`=`ctr`−1. The count test then uses `ctr`−1. If `bo[1]`=1 the test needs `ctr`−1 = 0, and otherwise it needs `ctr`−1 ≠ 0. A `ctr` of 1 therefore counts as reaching zero.
- R6: If `bo[2]`=1 there is no decrement (`ctr_we`=0) and the count test passes.
- R7: Register form (`op_form`=2) takes its target from `lr` when `tgt_sel`=0, from `ctr` when `tgt_sel`=1, and from `tar` when `tgt_sel` is 2 or 3. The two low bits of the target are cleared, and `op_abs` is ignored.
- R8: A register-form branch with `tgt_sel`=1 and `bo[2]`=0 performs no decrement (`ctr_we`=0) and skips the count test. Only the condition test applies.
- R9: When a branch is not taken, `nia_taken`=0 and `nia`=`cia`+4. Form 3 is never taken.
- R10: `lr_we` equals `op_lk`, and `lr_wdata`=`cia`+4, whether or not the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation valid |
| op_form | input | 2 | 0 immediate, 1 conditional displacement, 2 register, 3 reserved |
| op_abs | input | 1 | Absolute target (forms 0 and 1) |
| op_lk | input | 1 | Write link register |
| bo | input | 5 | Test and decrement control |
| bi | input | 5 | Condition bit index |
| tgt_sel | input | 2 | Register-form target source |
| disp | input | 24 | Word displacement (form 1 uses bits 13:0) |
| cia | input | 64 | Address of the branch |
| cr | input | 32 | Condition register |
| ctr | input | 64 | Count register |
| lr | input | 64 | Link register |
| tar | input | 64 | Target-address register |
| res_vld | output | 1 | Result valid |
| nia | output | 64 | Next instruction address |
| nia_taken | output | 1 | Branch redirects the flow |
| lr_we | output | 1 | Link write valid |
| lr_wdata | output | 64 | Link write value |
| ctr_we | output | 1 | Count write valid |
| ctr_wdata | output | 64 | Decremented count |

## Verification
Several properties are checked by the assertions on every cycle: the one-cycle valid timing, the quiet flags while idle, the fall-through address, the link value, the decremented count, the cleared low bits of register targets, and the missing count write for count-sourced targets. Some behaviour can only be shown by the bench's scenarios. These are the exact taken decision under each setting of the test and decrement controls, the bit order of the condition index, the one-to-zero count corner, sign extension of negative displacements, and absolute targets.

// File: rtl/branch_resolve.sv
module branch_resolve #(
  parameter int XLEN = 64,
  parameter int CRW  = 32,
  parameter int LIW  = 24,
  parameter int CDW  = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_vld,
  input  logic [1:0]               op_form,
  input  logic                     op_abs,
  input  logic                     op_lk,
  input  logic [4:0]               bo,
  input  logic [$clog2(CRW)-1:0]   bi,
  input  logic [1:0]               tgt_sel,
  input  logic [LIW-1:0]           disp,
  input  logic [XLEN-1:0]          cia,
  input  logic [CRW-1:0]           cr,
  input  logic [XLEN-1:0]          ctr,
  input  logic [XLEN-1:0]          lr,
  input  logic [XLEN-1:0]          tar,
  output logic                     res_vld,
  output logic [XLEN-1:0]          nia,
  output logic                     nia_taken,
  output logic                     lr_we,
  output logic [XLEN-1:0]          lr_wdata,
  output logic                     ctr_we,
  output logic [XLEN-1:0]          ctr_wdata
);
  localparam int BIW = $clog2(CRW);
  localparam logic [1:0] F_IMM = 2'd0, F_CND = 2'd1, F_REG = 2'd2;

  logic [XLEN-1:0] seq_pc, base, li_off, bd_off, reg_src, target, ctr_dec, nia_d;
  logic cr_bit, cond_ok, ctr_src, dec_req, do_dec, ctr_ok, taken;

  assign seq_pc  = cia + XLEN'(4);
  assign base    = op_abs ? '0 : cia;
  assign li_off  = {{(XLEN-LIW-2){disp[LIW-1]}}, disp, 2'b00};
  assign bd_off  = {{(XLEN-CDW-2){disp[CDW-1]}}, disp[CDW-1:0], 2'b00};
  assign reg_src = (tgt_sel == 2'd0) ? lr : (tgt_sel == 2'd1) ? ctr : tar;

  assign cr_bit  = cr[BIW'(CRW-1) - bi];
  assign cond_ok = bo[4] | (cr_bit == bo[3]);

  assign ctr_src = (op_form == F_REG) && (tgt_sel == 2'd1);
  assign dec_req = !bo[2] && (op_form == F_CND || op_form == F_REG);
  assign do_dec  = dec_req && !ctr_src;
  assign ctr_dec = ctr - XLEN'(1);
  assign ctr_ok  = !do_dec || ((ctr_dec == '0) == bo[1]);

  always_comb begin
    target = base + li_off;
    taken  = 1'b0;
    case (op_form)
      F_IMM: begin target = base + li_off; taken = 1'b1; end
      F_CND: begin target = base + bd_off; taken = cond_ok && ctr_ok; end
      F_REG: begin target = {reg_src[XLEN-1:2], 2'b00}; taken = cond_ok && ctr_ok; end
      default: taken = 1'b0;
    endcase
  end

  assign nia_d = taken ? target : seq_pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_vld   <= 1'b0;
      nia       <= '0;
      nia_taken <= 1'b0;
      lr_we     <= 1'b0;
      lr_wdata  <= '0;
      ctr_we    <= 1'b0;
      ctr_wdata <= '0;
    end else begin
      res_vld   <= op_vld;
      nia       <= nia_d;
      nia_taken <= op_vld && taken;
      lr_we     <= op_vld && op_lk;
      lr_wdata  <= seq_pc;
      ctr_we    <= op_vld && do_dec;
      ctr_wdata <= ctr_dec;
    end
  end

  assert_vld_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld == $past(op_vld));
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> !(nia_taken || lr_we || ctr_we));
  assert_fallthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> (nia_taken || nia == $past(cia) + XLEN'(4)));
  assert_link_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> (lr_we == $past(op_lk) && lr_wdata == $past(cia) + XLEN'(4)));
  assert_ctr_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_vld |=> (!ctr_we || ctr_wdata == $past(ctr) - XLEN'(1)));
  assert_no_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && bo[2]) |=> !ctr_we);
  assert_reg_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_form == F_REG) |=> (!nia_taken || nia[1:0] == 2'b00));
  assert_ctr_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_vld && op_form == F_REG && tgt_sel == 2'd1) |=> !ctr_we);
endmodule

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic op_vld = 1'b0, op_abs = 1'b0, op_lk = 1'b0;
  logic [1:0] op_form = '0, tgt_sel = '0;
  logic [4:0] bo = '0, bi = '0;
  logic [23:0] disp = '0;
  logic [63:0] cia = '0, ctr = '0, lr = '0, tar = '0;
  logic [31:0] cr = '0;
  logic res_vld, nia_taken, lr_we, ctr_we;
  logic [63:0] nia, lr_wdata, ctr_wdata;

  always #2 clk = ~clk;

  branch_resolve u_dut (.clk, .rst_n, .op_vld, .op_form, .op_abs, .op_lk, .bo, .bi,
    .tgt_sel, .disp, .cia, .cr, .ctr, .lr, .tar, .res_vld, .nia, .nia_taken,
    .lr_we, .lr_wdata, .ctr_we, .ctr_wdata);

  typedef struct {
    logic [63:0] nia; logic tk; logic lwe; logic [63:0] lwd;
    logic cwe; logic [63:0] cwd; string tag;
  } exp_t;
  exp_t sb[$];
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  function automatic exp_t model(logic [1:0] f, logic a, logic k, logic [4:0] o,
      logic [4:0] i, logic [1:0] s, logic [23:0] d, logic [63:0] pc,
      logic [31:0] c, logic [63:0] n, logic [63:0] l, logic [63:0] t, string tag);
    exp_t e;
    logic [63:0] b, tg; logic cok, dec, nok, tk;
    b = a ? 64'd0 : pc;
    cok = o[4] || (c[31 - i] == o[3]);
    dec = !o[2] && (f == 2'd1 || f == 2'd2) && !(f == 2'd2 && s == 2'd1);
    nok = !dec || (((n - 64'd1) == 64'd0) == o[1]);
    tk = 1'b0; tg = 64'd0;
    if (f == 2'd0) begin tk = 1'b1; tg = b + {{38{d[23]}}, d, 2'b00}; end
    else if (f == 2'd1) begin tk = cok && nok; tg = b + {{48{d[13]}}, d[13:0], 2'b00}; end
    else if (f == 2'd2) begin
      tk = cok && nok;
      tg = (s == 2'd0) ? l : (s == 2'd1) ? n : t;
      tg[1:0] = 2'b00;
    end
    e.tk = tk; e.nia = tk ? tg : pc + 64'd4;
    e.lwe = k; e.lwd = pc + 64'd4;
    e.cwe = dec; e.cwd = n - 64'd1; e.tag = tag;
    return e;
  endfunction

  task automatic drive(string tag, logic [1:0] f, logic a, logic k, logic [4:0] o,
      logic [4:0] i, logic [1:0] s, logic [23:0] d, logic [63:0] pc,
      logic [31:0] c, logic [63:0] n, logic [63:0] l, logic [63:0] t);
    @(posedge clk); #1;
    op_vld = 1; op_form = f; op_abs = a; op_lk = k; bo = o; bi = i; tgt_sel = s;
    disp = d; cia = pc; cr = c; ctr = n; lr = l; tar = t;
    sb.push_back(model(f, a, k, o, i, s, d, pc, c, n, l, t, tag));
  endtask

  task automatic idle();
    @(posedge clk); #1; op_vld = 0; op_form = 2'd0; op_lk = 1; bo = 5'd0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (res_vld) begin
        exp_t e;
        n_vec++;
        if (sb.size() == 0) begin
          n_bad++; $display("FAIL R1: result without operation, got 1 exp 0");
        end else begin
          e = sb.pop_front();
          if (nia !== e.nia || nia_taken !== e.tk || lr_we !== e.lwe ||
              lr_wdata !== e.lwd || ctr_we !== e.cwe || (e.cwe && ctr_wdata !== e.cwd)) begin
            n_bad++;
            $display("FAIL %s: nia=%h tk=%b lwe=%b lwd=%h cwe=%b cwd=%h exp nia=%h tk=%b lwe=%b lwd=%h cwe=%b cwd=%h",
              e.tag, nia, nia_taken, lr_we, lr_wdata, ctr_we, ctr_wdata,
              e.nia, e.tk, e.lwe, e.lwd, e.cwe, e.cwd);
          end
        end
      end else begin
        n_vec++;
        if (nia_taken || lr_we || ctr_we) begin
          n_bad++;
          $display("FAIL R1: idle flags tk=%b lwe=%b cwe=%b exp 000", nia_taken, lr_we, ctr_we);
        end
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++; $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; n_vec++;
    if (res_vld || nia !== 64'd0 || nia_taken || lr_we || ctr_we) begin
      n_bad++; $display("FAIL R1: reset outputs vld=%b nia=%h exp 0 0", res_vld, nia);
    end
    rst_n = 1;
    // R2 immediate relative, positive and negative, with and without link
    drive("R2 rel+",  2'd0, 0, 0, 5'd0, 5'd0, 2'd0, 24'h000010, 64'h1000, 32'h0, 64'd5, 64'h0, 64'h0);
    drive("R2 rel-",  2'd0, 0, 1, 5'd0, 5'd0, 2'd0, 24'hFFFFFE, 64'h1000, 32'h0, 64'd5, 64'h0, 64'h0);
    drive("R2 abs",   2'd0, 1, 0, 5'd0, 5'd0, 2'd0, 24'h800000, 64'h4444, 32'h0, 64'd5, 64'h0, 64'h0);
    drive("R2 R10 abs lk", 2'd0, 1, 1, 5'd0, 5'd0, 2'd0, 24'h000003, 64'h8000, 32'h0, 64'd5, 64'h0, 64'h0);
    idle(); idle();
    // R3 R4 conditional displacement, CR bit test
    drive("R3 R4 bi0 match",  2'd1, 0, 0, 5'b01100, 5'd0,  2'd0, 24'h002000, 64'h2000, 32'h80000000, 64'd9, 64'h0, 64'h0);
    drive("R4 bi0 miss",      2'd1, 0, 1, 5'b01100, 5'd0,  2'd0, 24'h000004, 64'h2000, 32'h00000001, 64'd9, 64'h0, 64'h0);
    drive("R4 bi31 match",    2'd1, 0, 0, 5'b01100, 5'd31, 2'd0, 24'h000004, 64'h2000, 32'h00000001, 64'd9, 64'h0, 64'h0);
    drive("R4 want clear",    2'd1, 1, 0, 5'b00100, 5'd3,  2'd0, 24'h000040, 64'h2000, 32'hEFFFFFFF, 64'd9, 64'h0, 64'h0);
    drive("R4 ignore cond",   2'd1, 0, 0, 5'b10100, 5'd5,  2'd0, 24'h003FFF, 64'h2000, 32'h00000000, 64'd9, 64'h0, 64'h0);
    // R5 count decrement cases
    drive("R5 ctr1 zero",     2'd1, 0, 0, 5'b10010, 5'd0, 2'd0, 24'h000008, 64'h3000, 32'h0, 64'd1, 64'h0, 64'h0);
    drive("R5 ctr1 nonzero",  2'd1, 0, 0, 5'b10000, 5'd0, 2'd0, 24'h000008, 64'h3000, 32'h0, 64'd1, 64'h0, 64'h0);
    drive("R5 ctr2 nonzero",  2'd1, 0, 0, 5'b10000, 5'd0, 2'd0, 24'h000008, 64'h3000, 32'h0, 64'd2, 64'h0, 64'h0);
    drive("R5 ctr0 wrap",     2'd1, 0, 0, 5'b10010, 5'd0, 2'd0, 24'h000008, 64'h3000, 32'h0, 64'd0, 64'h0, 64'h0);
    drive("R5 R4 both",       2'd1, 0, 0, 5'b01010, 5'd2, 2'd0, 24'h000008, 64'h3000, 32'h20000000, 64'd1, 64'h0, 64'h0);
    drive("R6 no dec",        2'd1, 0, 0, 5'b10110, 5'd0, 2'd0, 24'h000008, 64'h3000, 32'h0, 64'd7, 64'h0, 64'h0);
    idle();
    // R7 R8 register form
    drive("R7 lr",            2'd2, 1, 1, 5'b10100, 5'd0, 2'd0, 24'h0, 64'h5000, 32'h0, 64'h1237, 64'hABCD_0003, 64'h9997);
    drive("R7 ctr",           2'd2, 0, 0, 5'b10100, 5'd0, 2'd1, 24'h0, 64'h5000, 32'h0, 64'h1237, 64'hABCD_0003, 64'h9997);
    drive("R7 tar",           2'd2, 0, 0, 5'b10100, 5'd0, 2'd2, 24'h0, 64'h5000, 32'h0, 64'h1237, 64'hABCD_0003, 64'h9997);
    drive("R7 tar sel3",      2'd2, 0, 1, 5'b10100, 5'd0, 2'd3, 24'h0, 64'h5000, 32'h0, 64'h1237, 64'hABCD_0003, 64'h9996);
    drive("R8 ctr src dec",   2'd2, 0, 0, 5'b10010, 5'd0, 2'd1, 24'h0, 64'h5000, 32'h0, 64'h5, 64'h0, 64'h0);
    drive("R8 ctr src cond miss", 2'd2, 0, 0, 5'b01000, 5'd1, 2'd1, 24'h0, 64'h5000, 32'h0, 64'h1, 64'h0, 64'h0);
    drive("R5 lr dec",        2'd2, 0, 0, 5'b10000, 5'd0, 2'd0, 24'h0, 64'h5000, 32'h0, 64'h2, 64'h7771, 64'h0);
    drive("R9 reg not taken", 2'd2, 0, 1, 5'b01100, 5'd4, 2'd2, 24'h0, 64'h6000, 32'h0, 64'h2, 64'h0, 64'h8888);
    drive("R9 form3",         2'd3, 0, 1, 5'b10100, 5'd0, 2'd0, 24'h12, 64'h7000, 32'h0, 64'h2, 64'h0, 64'h0);
    drive("R10 lk not taken", 2'd1, 0, 1, 5'b00100, 5'd0, 2'd0, 24'h20, 64'hFFFF_FFFF_FFFF_FFFC, 32'h80000000, 64'h2, 64'h0, 64'h0);
    idle(); idle(); idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad + sb.size());
    $finish;
  end
endmodule